// File: doc/BRIEF.md
# Boot Mode Latch and Guard

This block sets the operating mode of a chip from three mode-select pins. While reset is held low, the mode register follows the pins on every clock. When reset is released, the register keeps the pin value it took at the last clock edge of reset. From then on, the pins are ignored.

Software can ask for a new mode through a one-cycle write strobe that carries a 3-bit value. Whether that write is accepted depends on the current mode. Special modes may be rewritten freely. Normal single-chip mode allows one change to its two lower bits. Every other mode is locked. A rejected write leaves the register untouched, so the mode output always shows the value in force.

Besides the 3-bit mode, the block drives six decoded flags. Downstream logic uses them to tell the mode class apart and to tell whether an external bus exists and how wide it is.

Top module: `boot_mode_guard`

## Requirements
- R1: While `rst_n` is low, every rising clock edge loads `mode` from `mode_pins`. After release, `mode` holds the value taken at the last edge of reset.
- R2: After reset release, changes on `mode_pins` never alter `mode`.
- R3: The mode codes and their flags are listed below. Flag order is special, normal, emulation, expanded, wide, single_chip.

  | Code | Mode | Flags |
  |---|---|---|
  | 000 | special single chip | 100001 |
  | 001 | emulation expanded narrow | 001100 |
  | 010 | special test | 100000 |
  | 011 | emulation expanded wide | 001110 |
  | 100 | normal single chip | 010001 |
  | 101 | normal expanded narrow | 010100 |
  | 110 | peripheral | 000000 |
  | 111 | normal expanded wide | 010110 |

  The flags are combinational from `mode` in the default build.
- R4: In mode 000 or 010, a write with `wr_en` high replaces all three bits with `wr_data` at the next edge. This works any number of times.
- R5: In mode 000 or 010, a write of 110 is rejected and `mode` is unchanged.
- R6: In mode 100, a write takes only `wr_data[1:0]` as the new lower bits. `mode[2]` stays 1.
- R7: In mode 100, only the first accepted write takes effect. Later writes, even legal ones, are ignored until the next reset. Reset clears this write-once lock.
- R8: In mode 100, a write whose resulting code would be 110 is rejected. A rejected write does not use up the single allowed change.
- R9: In modes 001, 011, 101, 110 and 111, writes have no effect.
- R10: A write strobe present during reset is ignored. The pins decide the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the pins are sampled while it is low |
| mode_pins | input | 3 | Mode-select pins, most significant first |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 3 | Requested mode value |
| mode | output | 3 | Current operating mode |
| special_mode | output | 1 | Mode is 000 or 010 |
| normal_mode | output | 1 | Mode is 100, 101 or 111 |
| emulation_mode | output | 1 | Mode is 001 or 011 |
| expanded_bus | output | 1 | An external bus is present |
| wide_bus | output | 1 | The external bus is 16 bits wide |
| single_chip | output | 1 | No external bus |

## Verification
Pin sampling and the software write path meet at the reset release edge. A write strobe is held high through the whole of reset, with pins that differ from the written value. The bench then checks that the mode equals the pins and not the write data.

The write-once lock and the forbidden-value rule meet when the first write in normal single-chip mode targets the peripheral code. That write must be refused, and the following legal write must still be accepted once and only once.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
   localparam int unsigned MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      M_SPC_SINGLE = 3'b000,
      M_EMU_NARROW = 3'b001,
      M_SPC_TEST   = 3'b010,
      M_EMU_WIDE   = 3'b011,
      M_NRM_SINGLE = 3'b100,
      M_NRM_NARROW = 3'b101,
      M_PERIPH     = 3'b110,
      M_NRM_WIDE   = 3'b111
   } mode_e;

   typedef struct packed {
      logic special;
      logic normal;
      logic emulation;
      logic expanded;
      logic wide;
      logic single;
   } mode_flags_t;
endpackage

// File: rtl/bmg_write_policy.sv
// Decides whether a software write is allowed and which value it would produce.
module bmg_write_policy #(
   parameter int unsigned   MODE_W    = 3,
   parameter logic [MODE_W-1:0] FORBID_CODE = 3'b110,
   parameter logic [MODE_W-1:0] ONCE_CODE   = 3'b100,
   parameter logic [MODE_W-1:0] ONCE_MASK   = 3'b011
) (
   input  logic [MODE_W-1:0] cur_mode,
   input  logic              once_used,
   input  logic [MODE_W-1:0] wr_data,
   output logic              accept,
   output logic              consume_once,
   output logic [MODE_W-1:0] target
);
   import boot_mode_pkg::*;

   logic free_class;
   logic once_class;

   always_comb begin
      free_class = (cur_mode == MODE_W'(M_SPC_SINGLE)) ||
                   (cur_mode == MODE_W'(M_SPC_TEST));
      once_class = (cur_mode == ONCE_CODE);
      if (free_class)
         target = wr_data;
      else
         target = (wr_data & ONCE_MASK) | (cur_mode & ~ONCE_MASK);
      accept       = (free_class || (once_class && !once_used)) &&
                     (target != FORBID_CODE);
      consume_once = accept && once_class;
   end
endmodule

// File: rtl/bmg_mode_store.sv
// Mode register: follows the pins during reset, software-updated afterwards.
module bmg_mode_store #(
   parameter int unsigned MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] pins,
   input  logic              wr_en,
   input  logic              accept,
   input  logic              consume_once,
   input  logic [MODE_W-1:0] target,
   output logic [MODE_W-1:0] mode_q,
   output logic              once_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= pins;
      else if (wr_en && accept)
         mode_q <= target;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         once_q <= 1'b0;
      else if (wr_en && consume_once)
         once_q <= 1'b1;
   end
endmodule

// File: rtl/bmg_flag_decode.sv
// Turns the mode code into class and bus flags; optionally registered.
module bmg_flag_decode #(
   parameter int unsigned MODE_W   = 3,
   parameter bit          FLAG_REG = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [MODE_W-1:0]          mode,
   output boot_mode_pkg::mode_flags_t flags
);
   import boot_mode_pkg::*;

   mode_flags_t raw;

   always_comb begin
      raw           = '0;
      raw.special   = (mode == MODE_W'(M_SPC_SINGLE)) || (mode == MODE_W'(M_SPC_TEST));
      raw.emulation = (mode == MODE_W'(M_EMU_NARROW)) || (mode == MODE_W'(M_EMU_WIDE));
      raw.normal    = (mode == MODE_W'(M_NRM_SINGLE)) || (mode == MODE_W'(M_NRM_NARROW)) ||
                      (mode == MODE_W'(M_NRM_WIDE));
      raw.expanded  = mode[0];
      raw.wide      = mode[0] & mode[1];
      raw.single    = (mode == MODE_W'(M_SPC_SINGLE)) || (mode == MODE_W'(M_NRM_SINGLE));
   end

   generate
      if (FLAG_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags <= '0;
            else        flags <= raw;
         end
      end else begin : g_comb
         assign flags = raw;
      end
   endgenerate
endmodule

// File: rtl/boot_mode_guard.sv
module boot_mode_guard #(
   parameter int unsigned       MODE_W      = 3,
   parameter logic [MODE_W-1:0] FORBID_CODE = 3'b110,
   parameter logic [MODE_W-1:0] ONCE_CODE   = 3'b100,
   parameter logic [MODE_W-1:0] ONCE_MASK   = 3'b011,
   parameter bit                FLAG_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_pins,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output logic [MODE_W-1:0] mode,
   output logic              special_mode,
   output logic              normal_mode,
   output logic              emulation_mode,
   output logic              expanded_bus,
   output logic              wide_bus,
   output logic              single_chip
);
   import boot_mode_pkg::*;

   localparam int unsigned CODES = 1 << MODE_W;

   generate
      if (MODE_W != boot_mode_pkg::MODE_W) begin : g_bad_width
         $error("boot_mode_guard: MODE_W must equal the package mode width");
      end
      if (int'(FORBID_CODE) >= CODES || ONCE_MASK == '0) begin : g_bad_codes
         $error("boot_mode_guard: forbidden code or once mask out of range");
      end
   endgenerate

   logic              accept;
   logic              consume_once;
   logic [MODE_W-1:0] target;
   logic              once_q;
   mode_flags_t       flags;

   bmg_write_policy #(
      .MODE_W(MODE_W), .FORBID_CODE(FORBID_CODE),
      .ONCE_CODE(ONCE_CODE), .ONCE_MASK(ONCE_MASK)
   ) u_policy (
      .cur_mode(mode), .once_used(once_q), .wr_data(wr_data),
      .accept(accept), .consume_once(consume_once), .target(target)
   );

   bmg_mode_store #(.MODE_W(MODE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .pins(mode_pins), .wr_en(wr_en),
      .accept(accept), .consume_once(consume_once), .target(target),
      .mode_q(mode), .once_q(once_q)
   );

   bmg_flag_decode #(.MODE_W(MODE_W), .FLAG_REG(FLAG_REG)) u_decode (
      .clk(clk), .rst_n(rst_n), .mode(mode), .flags(flags)
   );

   assign special_mode   = flags.special;
   assign normal_mode    = flags.normal;
   assign emulation_mode = flags.emulation;
   assign expanded_bus   = flags.expanded;
   assign wide_bus       = flags.wide;
   assign single_chip    = flags.single;
endmodule

// File: rtl/boot_mode_guard_chk.sv
module boot_mode_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode,
   input logic       wr_en,
   input logic       once_q,
   input logic       special_mode,
   input logic       normal_mode,
   input logic       emulation_mode,
   input logic       expanded_bus,
   input logic       wide_bus
);
   logic locked;
   assign locked = (mode == 3'b001) || (mode == 3'b011) || (mode == 3'b101) ||
                   (mode == 3'b110) || (mode == 3'b111);

   // R2: with no write, the mode holds whatever the pins do
   p_pins_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode));

   // R5 and R8: software can never reach the forbidden code
   p_no_forbidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 3'b110 |=> mode != 3'b110);

   // R9: locked modes never change
   p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode));

   // R7: once the single change is used, the mode is frozen
   p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      once_q |=> $stable(mode));

   // R6: normal single-chip keeps its top bit
   p_keep_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'b100 |=> mode[2]);

   // R3: class flags are exclusive and wide implies expanded
   p_class_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({special_mode, normal_mode, emulation_mode}));
   p_wide_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wide_bus |-> expanded_bus);
endmodule

bind boot_mode_guard boot_mode_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .once_q(once_q),
   .special_mode(special_mode), .normal_mode(normal_mode),
   .emulation_mode(emulation_mode), .expanded_bus(expanded_bus),
   .wide_bus(wide_bus)
);

// File: tb/tb_boot_mode_guard.sv
`timescale 1ns/1ps
module tb_boot_mode_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_pins = 3'b000;
   logic       wr_en = 1'b0;
   logic [2:0] wr_data = 3'b000;
   logic [2:0] mode;
   logic       special_mode, normal_mode, emulation_mode;
   logic       expanded_bus, wide_bus, single_chip;

   always #2 clk = ~clk;

   boot_mode_guard dut (
      .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .wr_en(wr_en),
      .wr_data(wr_data), .mode(mode), .special_mode(special_mode),
      .normal_mode(normal_mode), .emulation_mode(emulation_mode),
      .expanded_bus(expanded_bus), .wide_bus(wide_bus), .single_chip(single_chip)
   );

   typedef struct {
      logic [2:0] m;
      logic [5:0] f;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   logic [2:0] m_mode;
   logic       m_once;

   // R3 flag table: special, normal, emulation, expanded, wide, single
   function automatic logic [5:0] flags_of(input logic [2:0] m);
      case (m)
         3'b000:  return 6'b100001;
         3'b001:  return 6'b001100;
         3'b010:  return 6'b100000;
         3'b011:  return 6'b001110;
         3'b100:  return 6'b010001;
         3'b101:  return 6'b010100;
         3'b110:  return 6'b000000;
         default: return 6'b010110;
      endcase
   endfunction

   task automatic push_exp(input string tag);
      exp_t e;
      e.m = m_mode; e.f = flags_of(m_mode); e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: pop and compare half a cycle after the edge that produced a result
   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t e;
         logic [5:0] got_f;
         e = q.pop_front();
         got_f = {special_mode, normal_mode, emulation_mode, expanded_bus, wide_bus, single_chip};
         checks++;
         if (mode !== e.m || got_f !== e.f) begin
            errors++;
            $display("FAIL %s: mode=%b flags=%b expected mode=%b flags=%b",
                     e.tag, mode, got_f, e.m, e.f);
         end
      end
   end

   task automatic reset_seq(input logic [2:0] pins, input logic wr_hold,
                            input logic [2:0] wd, input string tag);
      @(negedge clk);
      rst_n = 1'b0; mode_pins = pins; wr_en = wr_hold; wr_data = wd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; wr_en = 1'b0;
      m_mode = pins; m_once = 1'b0;
      @(posedge clk);
      push_exp(tag);
      @(negedge clk);
      mode_pins = ~pins;
   endtask

   task automatic idle_check(input string tag);
      @(posedge clk);
      push_exp(tag);
      @(negedge clk);
   endtask

   task automatic write(input logic [2:0] d, input string tag);
      logic       free_c, once_c;
      logic [2:0] tgt;
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      free_c = (m_mode == 3'b000) || (m_mode == 3'b010);
      once_c = (m_mode == 3'b100);
      tgt = free_c ? d : {m_mode[2], d[1:0]};
      if ((free_c || (once_c && !m_once)) && tgt != 3'b110) begin
         m_mode = tgt;
         if (once_c) m_once = 1'b1;
      end
      @(posedge clk);
      push_exp(tag);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1, R3: sample special single chip, then R2: pins flip to 111
      reset_seq(3'b000, 1'b0, 3'b000, "R1 sample 000");
      idle_check("R2 pins change after release");
      write(3'b011, "R4 special rewrite to 011");
      write(3'b000, "R9 emulation wide locked");

      // special test: forbidden target, then repeated rewrites
      reset_seq(3'b010, 1'b0, 3'b000, "R1 sample 010");
      write(3'b110, "R5 forbidden target rejected");
      write(3'b000, "R4 rewrite to 000");
      write(3'b010, "R4 rewrite to 010");
      write(3'b100, "R4 rewrite to 100");
      write(3'b011, "R6 low bits only, msb kept");
      write(3'b100, "R9 normal wide locked");

      // normal single chip: forbidden first, then write-once
      reset_seq(3'b100, 1'b0, 3'b000, "R1 sample 100");
      write(3'b010, "R8 target 110 rejected");
      write(3'b000, "R7 first accepted write");
      write(3'b001, "R7 second write ignored");
      reset_seq(3'b100, 1'b0, 3'b000, "R7 reset clears lock");
      write(3'b001, "R7 change allowed after reset");

      // locked modes
      for (int p = 0; p < 8; p++) begin
         if (p == 1 || p == 3 || p >= 5) begin
            reset_seq(3'(p), 1'b0, 3'b000, "R3 flags after sample");
            write(3'b000, "R9 locked mode ignores write");
         end
      end

      // R10: write held through reset
      reset_seq(3'b000, 1'b1, 3'b100, "R10 write during reset ignored");
      reset_seq(3'b100, 1'b1, 3'b000, "R10 write during reset ignored");

      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule